// File: doc/BRIEF.md
# Transmit Squelch and Idle Inserter

This block stands between the transmit pair of an attachment interface and the driver of a fiber-optic LED. Each clock cycle it sees one oversampled view of the transmit line. That view is two flags: the sign of the line and whether its magnitude passes the squelch threshold. From these the block decides whether a real packet is on the line. While it is squelched, it sends a free-running square-wave idle tone to the LED in place of line data. A negative-going excursion must last a minimum number of samples before the block opens and passes data. Once open, the block closes again when the line has shown no negative signal for a set number of consecutive samples.

The inhibit input comes from the jabber and low-light logic. It blocks data from the LED and keeps the idle tone going. The transmit-active flag is not affected by inhibit, so the collision and jabber logic still see where packets start and end. The pulse-width limit, the idle-time limit and the half period of the tone are parameters counted in samples. With a 100 MHz sample rate, the defaults are 20 ns, 180 ns and 1 MHz.

Top module: `tx_squelch_idle`

## Requirements
- R1: A sample is qualified negative only when `line_neg`=1 and `line_thr`=1 in the same cycle. A line with the negative sign but below threshold, or above threshold with the positive sign, counts as no signal and never opens the block.
- R2: While squelched, a run of fewer than OPEN_MIN (default 2) consecutive qualified-negative samples leaves `tx_active` low.
- R3: A run of OPEN_MIN consecutive qualified-negative samples opens the block. `tx_active` goes high after the clock edge that follows the last sample of the run, which is OPEN_MIN+1 edges after the first sample.
- R4: While open, a gap of fewer than IDLE_MIN (default 18) consecutive non-negative samples keeps `tx_active` high.
- R5: IDLE_MIN consecutive non-negative samples close the block. `tx_active` falls one edge after the last sample of the gap, which is IDLE_MIN+1 edges after the first.
- R6: While squelched, `led_on` carries a square wave that stays TONE_HALF (default 50) samples high and TONE_HALF samples low.
- R7: While open and not inhibited, `led_on` equals the qualified-negative value sampled two edges earlier. 1 means LED on (negative line) and 0 means LED off. At most OPEN_MIN samples at packet start are lost.
- R8: While `inhibit`=1, `led_on` carries the idle tone whatever the line does, and `tx_active` still follows the squelch decision.
- R9: Synchronous reset drives `tx_active` and `led_on` low and restarts the tone divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| line_neg | input | 1 | Sign of the transmit line: 1 = negative |
| line_thr | input | 1 | Line magnitude exceeds the squelch threshold |
| inhibit | input | 1 | Block data and send idle tone (jabber or low light) |
| led_on | output | 1 | Optical drive bit: 1 = LED emitting |
| tx_active | output | 1 | High from unsquelch until squelch is re-entered |

## Verification
The hardest cases to reach are the exact count boundaries. A run one sample short of OPEN_MIN, or a gap one sample short of IDLE_MIN, must leave the state unchanged, while one more sample must flip it on a specific edge. The bench drives one sample per cycle on the falling edge and checks `tx_active` just before and just after the edge where the change must happen. Inhibit is raised while the block is already open, with a constant negative line. This isolates the tone on `led_on` from data while `tx_active` stays high.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    typedef enum logic {
        SQ_CLOSED = 1'b0,
        SQ_OPEN   = 1'b1
    } sq_state_e;

    typedef struct packed {
        logic neg;
        logic thr;
    } line_sample_t;

    function automatic logic sample_is_neg(input line_sample_t s);
        return s.neg & s.thr;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tsq_front.sv
module tsq_front
    import tsq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  line_sample_t line_i,
    output logic         neg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            neg_q <= 1'b0;
        end else begin
            neg_q <= sample_is_neg(line_i);
        end
    end

endmodule

// File: rtl/tsq_squelch_fsm.sv
module tsq_squelch_fsm
    import tsq_pkg::*;
#(
    parameter int unsigned OPEN_MIN = 2,
    parameter int unsigned IDLE_MIN = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic neg_q,
    output logic open_o
);

    localparam int unsigned RUN_MAX = max2(OPEN_MIN, IDLE_MIN);
    localparam int unsigned CW      = $clog2(RUN_MAX + 1);
    localparam logic [CW-1:0] OPEN_LAST = CW'(OPEN_MIN - 1);
    localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_MIN - 1);

    sq_state_e     state;
    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_CLOSED;
            run   <= '0;
        end else begin
            case (state)
                SQ_CLOSED: begin
                    if (neg_q) begin
                        if (run == OPEN_LAST) begin
                            state <= SQ_OPEN;
                            run   <= '0;
                        end else begin
                            run <= run + 1'b1;
                        end
                    end else begin
                        run <= '0;
                    end
                end
                default: begin
                    if (!neg_q) begin
                        if (run == IDLE_LAST) begin
                            state <= SQ_CLOSED;
                            run   <= '0;
                        end else begin
                            run <= run + 1'b1;
                        end
                    end else begin
                        run <= '0;
                    end
                end
            endcase
        end
    end

    assign open_o = (state == SQ_OPEN);

endmodule

// File: rtl/tsq_idle_tone.sv
module tsq_idle_tone #(
    parameter int unsigned TONE_HALF = 50
) (
    input  logic clk,
    input  logic rst,
    output logic tone_o
);

    localparam int unsigned TW = $clog2(TONE_HALF + 1);
    localparam logic [TW-1:0] HALF_LAST = TW'(TONE_HALF - 1);

    logic [TW-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            tone_o  <= 1'b0;
        end else if (div_cnt == HALF_LAST) begin
            div_cnt <= '0;
            tone_o  <= ~tone_o;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tx_squelch_idle.sv
module tx_squelch_idle
    import tsq_pkg::*;
#(
    parameter int unsigned OPEN_MIN  = 2,
    parameter int unsigned IDLE_MIN  = 18,
    parameter int unsigned TONE_HALF = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic line_neg,
    input  logic line_thr,
    input  logic inhibit,
    output logic led_on,
    output logic tx_active
);

    line_sample_t line_s;
    logic         neg_q;
    logic         open_w;
    logic         tone_w;

    assign line_s.neg = line_neg;
    assign line_s.thr = line_thr;

    tsq_front u_front (
        .clk   (clk),
        .rst   (rst),
        .line_i(line_s),
        .neg_q (neg_q)
    );

    tsq_squelch_fsm #(
        .OPEN_MIN(OPEN_MIN),
        .IDLE_MIN(IDLE_MIN)
    ) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .neg_q (neg_q),
        .open_o(open_w)
    );

    tsq_idle_tone #(
        .TONE_HALF(TONE_HALF)
    ) u_tone (
        .clk   (clk),
        .rst   (rst),
        .tone_o(tone_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            led_on <= 1'b0;
        end else if (open_w && !inhibit) begin
            led_on <= neg_q;
        end else begin
            led_on <= tone_w;
        end
    end

    assign tx_active = open_w;

endmodule

// File: rtl/tsq_checker.sv
module tsq_checker #(
    parameter int unsigned TONE_HALF = 50
) (
    input logic clk,
    input logic rst,
    input logic line_neg,
    input logic line_thr,
    input logic inhibit,
    input logic led_on,
    input logic tx_active
);

    localparam int unsigned RW = $clog2(TONE_HALF + 4) + 1;
    localparam logic [RW-1:0] RUN_CAP = RW'(TONE_HALF + 2);

    logic          qneg;
    logic          led_d;
    logic [RW-1:0] run_cnt;

    assign qneg = line_neg & line_thr;

    // length of the current stable stretch of led_on while tone is expected
    always_ff @(posedge clk) begin
        if (rst) begin
            led_d   <= 1'b0;
            run_cnt <= '0;
        end else begin
            led_d <= led_on;
            if ((tx_active && !inhibit) || (led_on != led_d)) begin
                run_cnt <= '0;
            end else if (run_cnt != '1) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    a_r3_open_needs_neg: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_active) |-> $past(qneg, 2));

    a_r5_close_after_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_active) |-> !$past(qneg, 2));

    a_r6_tone_run_bounded: assert property (@(posedge clk) disable iff (rst)
        !tx_active |-> (run_cnt <= RUN_CAP));

    a_r8_inhibit_tone: assert property (@(posedge clk) disable iff (rst)
        inhibit |-> (run_cnt <= RUN_CAP));

    a_r7_data_follows_line: assert property (@(posedge clk) disable iff (rst)
        ($past(tx_active) && !$past(inhibit)) |-> (led_on == $past(qneg, 2)));

endmodule

bind tx_squelch_idle tsq_checker #(
    .TONE_HALF(TONE_HALF)
) u_tsq_checker (
    .clk      (clk),
    .rst      (rst),
    .line_neg (line_neg),
    .line_thr (line_thr),
    .inhibit  (inhibit),
    .led_on   (led_on),
    .tx_active(tx_active)
);

// File: tb/tx_squelch_idle_bench.sv
`timescale 1ns/1ps
module tx_squelch_idle_bench;

    localparam int OPEN_MIN  = 2;
    localparam int IDLE_MIN  = 18;
    localparam int TONE_HALF = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_neg = 1'b0;
    logic line_thr = 1'b0;
    logic inhibit = 1'b0;
    logic led_on;
    logic tx_active;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tx_squelch_idle #(
        .OPEN_MIN (OPEN_MIN),
        .IDLE_MIN (IDLE_MIN),
        .TONE_HALF(TONE_HALF)
    ) u_tx_squelch_idle (
        .clk      (clk),
        .rst      (rst),
        .line_neg (line_neg),
        .line_thr (line_thr),
        .inhibit  (inhibit),
        .led_on   (led_on),
        .tx_active(tx_active)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one sample for the next rising edge, return at the following falling edge
    task automatic step(input logic n, input logic t);
        line_neg = n;
        line_thr = t;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        inhibit = 1'b0;
        line_neg = 1'b0;
        line_thr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic open_block();
        repeat (OPEN_MIN + 2) step(1'b1, 1'b1);
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R9 tx_active after reset", tx_active, 0);
        check("R9 led_on after reset", led_on, 0);
    endtask

    task automatic t_threshold_qualify();
        do_reset();
        repeat (10) step(1'b1, 1'b0);
        check("R1 negative sign below threshold", tx_active, 0);
        repeat (10) step(1'b0, 1'b1);
        check("R1 positive sign above threshold", tx_active, 0);
    endtask

    task automatic t_open_boundary();
        do_reset();
        repeat (OPEN_MIN - 1) step(1'b1, 1'b1);
        repeat (6) step(1'b0, 1'b0);
        check("R2 short pulse keeps squelch", tx_active, 0);
        repeat (OPEN_MIN) step(1'b1, 1'b1);
        check("R3 not yet open before final edge", tx_active, 0);
        step(1'b1, 1'b1);
        check("R3 open after qualified run", tx_active, 1);
    endtask

    task automatic t_close_boundary();
        do_reset();
        open_block();
        repeat (IDLE_MIN - 1) step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        check("R4 short gap keeps open", tx_active, 1);
        repeat (IDLE_MIN) step(1'b0, 1'b0);
        check("R5 still open before final edge", tx_active, 1);
        step(1'b0, 1'b0);
        check("R5 closed after idle gap", tx_active, 0);
    endtask

    task automatic t_tone_period();
        int hi_run;
        int lo_run;
        int guard;
        do_reset();
        guard = 0;
        while (led_on != 1'b1 && guard < 4 * TONE_HALF) begin
            step(1'b0, 1'b0);
            guard++;
        end
        hi_run = 0;
        while (led_on == 1'b1 && hi_run < 4 * TONE_HALF) begin
            step(1'b0, 1'b0);
            hi_run++;
        end
        lo_run = 0;
        while (led_on == 1'b0 && lo_run < 4 * TONE_HALF) begin
            step(1'b0, 1'b0);
            lo_run++;
        end
        check("R6 tone high length", hi_run, TONE_HALF);
        check("R6 tone low length", lo_run, TONE_HALF);
        check("R6 squelched during tone", tx_active, 0);
    endtask

    task automatic t_data_pass();
        logic prev;
        logic cur;
        int bad;
        do_reset();
        open_block();
        prev = 1'b1;
        bad = 0;
        for (int i = 0; i < 48; i++) begin
            cur = ((i / 3) % 2 == 0) ? 1'b0 : 1'b1;
            if (i % 7 == 0) cur = ~cur;
            step(cur, cur);
            checks++;
            if (led_on != prev) begin
                fails++;
                bad++;
                $display("FAIL R7 data sample %0d: actual %0d expected %0d", i, led_on, prev);
            end
            prev = cur;
        end
        check("R7 block open during data", tx_active, 1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        check("R7 negative line gives LED on", led_on, 1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        check("R7 positive line gives LED off", led_on, 0);
    endtask

    task automatic t_inhibit();
        int highs;
        int lows;
        do_reset();
        open_block();
        inhibit = 1'b1;
        highs = 0;
        lows = 0;
        for (int i = 0; i < 3 * TONE_HALF; i++) begin
            step(1'b1, 1'b1);
            if (i > 1) begin
                if (led_on) highs++;
                else lows++;
            end
        end
        check("R8 tone high samples under inhibit", highs >= TONE_HALF - 2, 1);
        check("R8 tone low samples under inhibit", lows >= TONE_HALF - 2, 1);
        check("R8 tx_active kept under inhibit", tx_active, 1);
        inhibit = 1'b0;
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        check("R8 data resumes after inhibit", led_on, 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_threshold_qualify();
        t_open_boundary();
        t_close_boundary();
        t_tone_period();
        t_data_pass();
        t_inhibit();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule